// File: doc/BRIEF.md
# DMA Request Front End

This block takes the asynchronous transfer-request lines of a small multi-channel DMA engine and turns them into one clean offer to the bus-cycle sequencer. Each request line is captured on the falling clock edge and passed through a short falling-edge synchronizer. It is then latched as pending and arbitrated against the other channels. The winning channel is offered to the sequencer through a request/acknowledge pair, along with its channel index and the transfer direction that its synchronization mode implies.

While the sequencer runs the cycle, it reports how many clocks are left. When that count reaches a fixed threshold, the block drops the channel's pending state and flushes its synchronizer. This re-arms the input, so a peripheral that still holds its request gets a new transfer right after the current one ends. The re-armed request always goes through the full capture latency again. Each channel has its own enable, a fixed-priority bit and a synchronization-mode bit. Channels of equal priority take turns.

Top module: `dmarq_front`

## Requirements
- R1: While reset is low at a rising edge, `cyc_req` is 0, `cyc_ch` is 0 and `cyc_dest` is 0.
- R2: A request line is captured on a falling edge. With the default two synchronizer stages and no competing work, `cyc_req` rises at the third rising edge after the capturing falling edge, with `cyc_ch` set to that channel's index.
- R3: Once a request has been captured and latched as pending, it is offered even if the input line falls again before the offer.
- R4: While `cyc_req` is 1 and `cyc_ack` is 0 at a rising edge, `cyc_req`, `cyc_ch` and `cyc_dest` hold. A rising edge with both at 1 starts the offered channel's cycle and lowers `cyc_req` at that edge.
- R5: When several enabled channels compete, those with `ch_prio` bit set to 1 win over those with 0.
- R6: Among competitors of equal priority, the winner is the first channel after the most recently offered one in ascending index order, wrapping around. After reset, channel 0 wins first.
- R7: `cyc_dest` carries the offered channel's `ch_dest_sync` bit. 0 means source-synchronized (peripheral to memory) and 1 means destination-synchronized (memory to peripheral).
- R8: At the rising edge where a channel's cycle is running and `cyc_left` equals 4, its pending state clears and its synchronizer is flushed at the next falling edge. A line held high is then captured anew. Its `cyc_req` rises at the rising edge right after the clock in which `cyc_left` is 1. A line that has gone low produces no new offer.
- R9: A channel whose `ch_enable` bit is 0 has its input masked and its synchronizer and not-yet-offered pending state cleared. After the bit returns to 1, a held request again needs the full R2 latency.
- R10: A channel whose cycle is running or whose request is on `cyc_req` is not offered again until it re-arms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; capture on falling edge, control on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | NCH | Asynchronous per-channel transfer requests |
| ch_enable | input | NCH | Per-channel enable; 0 masks and clears the channel |
| ch_prio | input | NCH | Per-channel fixed-priority bit; 1 wins over 0 |
| ch_dest_sync | input | NCH | Per-channel mode: 0 source-synchronized, 1 destination-synchronized |
| cyc_req | output | 1 | Offer of a channel to the bus-cycle sequencer |
| cyc_ch | output | IDX_W | Index of the offered channel |
| cyc_dest | output | 1 | Mode of the offered channel (direction of the transfer) |
| cyc_ack | input | 1 | Sequencer accepts the offer; the cycle starts |
| cyc_left | input | LEFT_W | Clocks remaining in the running cycle, counting the current one |

## Verification
The properties rely on the sequencer behaving well. It acknowledges only while an offer is up, and it never acknowledges a second cycle while one is still running. Each running cycle lasts at least four clocks, and its remaining-clock count steps down by one per clock and reaches the re-arm value exactly once. The bench's sequencer task keeps to these rules. It pulses the acknowledge for one clock, then counts the given length down to one before it idles at zero, and it is only called with lengths of four or more. Request, enable and mode inputs change just after a falling edge, so each capture happens at a known falling edge and the expected offer cycle can be counted exactly.

// File: rtl/dmarq_pkg.sv
`timescale 1ns/1ps
// Shared types for the DMA request front end.
package dmarq_pkg;
    // Synchronization mode of a channel; selects the transfer direction.
    typedef enum logic {
        SRC_SYNC = 1'b0,   // peripheral supplies data (to memory)
        DST_SYNC = 1'b1    // peripheral receives data (from memory)
    } sync_mode_e;
endpackage

// File: rtl/dmarq_sync.sv
`timescale 1ns/1ps
// Per-channel request synchronizer.
// Captures an asynchronous request on the falling clock edge and shifts it
// through STAGES falling-edge flops. A low enable or a flush pulse empties the
// chain, so a request that is held must be captured again from scratch.
// Assumes STAGES >= 2 and that flush comes from rising-edge logic.
module dmarq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic flush,
    input  logic req_async,
    output logic req_sync
);
    logic [STAGES-1:0] chain_q;

    // Falling-edge shift chain, cleared on reset, disable or flush.
    always_ff @(negedge clk) begin
        if (!rst_n || !enable || flush) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], req_async};
        end
    end

    assign req_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dmarq_arb.sv
`timescale 1ns/1ps
// Channel arbiter (combinational).
// Channels with their priority bit set are considered first. Within the chosen
// pool the search starts after the last offered channel and wraps around.
// Assumes NCH >= 2.
module dmarq_arb #(
    parameter int NCH   = 2,
    parameter int IDX_W = 1
) (
    input  logic [NCH-1:0]   cand,
    input  logic [NCH-1:0]   prio,
    input  logic [IDX_W-1:0] last,
    output logic             any,
    output logic [IDX_W-1:0] win
);
    logic [NCH-1:0]   hi_pool;
    logic [NCH-1:0]   pool;
    logic [IDX_W-1:0] idx;

    // Pick the pool, then rotate from last+1; the nearest candidate wins.
    always_comb begin
        hi_pool = cand & prio;
        pool    = (|hi_pool) ? hi_pool : cand;
        win     = '0;
        idx     = '0;
        for (int k = NCH; k >= 1; k--) begin
            idx = IDX_W'((int'(last) + k) % NCH);
            if (pool[idx]) win = idx;
        end
    end

    assign any = |cand;
endmodule

// File: rtl/dmarq_front.sv
`timescale 1ns/1ps
// DMA request front end (top).
// Synchronizes the per-channel request lines, keeps a pending bit per
// channel, offers one winning channel at a time to the bus-cycle sequencer
// and re-arms the channel when REARM_LEFT clocks of its cycle remain.
// Assumes the sequencer acknowledges only a raised offer, runs one cycle at
// a time, and counts each cycle down through REARM_LEFT.
module dmarq_front
    import dmarq_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2,
    parameter int LEFT_W      = 4,
    parameter int REARM_LEFT  = 4,
    localparam int IDX_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req_in,
    input  logic [NCH-1:0]    ch_enable,
    input  logic [NCH-1:0]    ch_prio,
    input  logic [NCH-1:0]    ch_dest_sync,
    output logic              cyc_req,
    output logic [IDX_W-1:0]  cyc_ch,
    output logic              cyc_dest,
    input  logic              cyc_ack,
    input  logic [LEFT_W-1:0] cyc_left
);
    logic [NCH-1:0]   req_sync;
    logic [NCH-1:0]   pend_q;
    logic [NCH-1:0]   rearm_q;
    logic [NCH-1:0]   offer_mask;
    logic [NCH-1:0]   act_mask;
    logic [NCH-1:0]   end_mask;
    logic [NCH-1:0]   cand;
    logic             act_q;
    logic [IDX_W-1:0] act_ch;
    logic [IDX_W-1:0] last_q;
    logic             arb_any;
    logic [IDX_W-1:0] arb_win;
    logic             ending;
    sync_mode_e       mode_q;

    // Channel masks: offered, running, and re-arming this clock.
    always_comb begin
        ending     = act_q && (cyc_left == LEFT_W'(REARM_LEFT));
        offer_mask = cyc_req ? (NCH'(1) << cyc_ch) : '0;
        act_mask   = act_q ? (NCH'(1) << act_ch) : '0;
        end_mask   = ending ? act_mask : '0;
        cand       = pend_q & ch_enable & ~offer_mask & ~act_mask;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dmarq_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (ch_enable[c]),
            .flush     (rearm_q[c]),
            .req_async (req_in[c]),
            .req_sync  (req_sync[c])
        );

        // Pending bit: cleared on re-arm or disable, set by a synchronized request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[c] <= 1'b0;
            end else if (end_mask[c]) begin
                pend_q[c] <= 1'b0;
            end else if (!ch_enable[c] && !offer_mask[c] && !act_mask[c]) begin
                pend_q[c] <= 1'b0;
            end else if (req_sync[c]) begin
                pend_q[c] <= 1'b1;
            end
        end

        // One-clock flush pulse into the synchronizer after re-arm.
        always_ff @(posedge clk) begin
            if (!rst_n) rearm_q[c] <= 1'b0;
            else        rearm_q[c] <= end_mask[c];
        end
    end

    dmarq_arb #(.NCH(NCH), .IDX_W(IDX_W)) i_arb (
        .cand (cand),
        .prio (ch_prio),
        .last (last_q),
        .any  (arb_any),
        .win  (arb_win)
    );

    // Offer register: raise on a winner, hold until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_req <= 1'b0;
            cyc_ch  <= '0;
            mode_q  <= SRC_SYNC;
            last_q  <= IDX_W'(NCH - 1);
        end else if (cyc_req) begin
            if (cyc_ack) cyc_req <= 1'b0;
        end else if (arb_any) begin
            cyc_req <= 1'b1;
            cyc_ch  <= arb_win;
            mode_q  <= sync_mode_e'(ch_dest_sync[arb_win]);
            last_q  <= arb_win;
        end
    end

    // Running-cycle tracker: starts on acknowledge, ends at re-arm point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            act_ch <= '0;
        end else begin
            if (ending) act_q <= 1'b0;
            if (cyc_req && cyc_ack) begin
                act_q  <= 1'b1;
                act_ch <= cyc_ch;
            end
        end
    end

    assign cyc_dest = (mode_q == DST_SYNC);
endmodule

// File: rtl/dmarq_front_chk.sv
`timescale 1ns/1ps
// Property checker for dmarq_front, attached by bind below.
// Observes the ports plus the pending and running-cycle state.
module dmarq_front_chk #(
    parameter int NCH        = 2,
    parameter int IDX_W      = 1,
    parameter int LEFT_W     = 4,
    parameter int REARM_LEFT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    ch_enable,
    input logic [NCH-1:0]    ch_prio,
    input logic              cyc_req,
    input logic [IDX_W-1:0]  cyc_ch,
    input logic              cyc_dest,
    input logic              cyc_ack,
    input logic [LEFT_W-1:0] cyc_left,
    input logic [NCH-1:0]    pend_q,
    input logic              act_q,
    input logic [IDX_W-1:0]  act_ch
);
    // R4
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_req && !cyc_ack |=> cyc_req && $stable(cyc_ch) && $stable(cyc_dest));

    // R4
    offer_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_req && cyc_ack |=> !cyc_req);

    // R9
    offer_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_req) |-> ((($past(ch_enable) >> cyc_ch) & NCH'(1)) != '0));

    // R5
    prio_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_req) && $past(ch_prio != '0 && ch_prio != '1 &&
                                (pend_q & ch_enable) == '1 && !act_q)
        |-> ((($past(ch_prio) >> cyc_ch) & NCH'(1)) != '0));

    // R8
    rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_q && cyc_left == LEFT_W'(REARM_LEFT)
        |=> (((pend_q >> $past(act_ch)) & NCH'(1)) == '0));
endmodule

bind dmarq_front dmarq_front_chk #(
    .NCH        (NCH),
    .IDX_W      (IDX_W),
    .LEFT_W     (LEFT_W),
    .REARM_LEFT (REARM_LEFT)
) i_dmarq_front_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_enable (ch_enable),
    .ch_prio   (ch_prio),
    .cyc_req   (cyc_req),
    .cyc_ch    (cyc_ch),
    .cyc_dest  (cyc_dest),
    .cyc_ack   (cyc_ack),
    .cyc_left  (cyc_left),
    .pend_q    (pend_q),
    .act_q     (act_q),
    .act_ch    (act_ch)
);

// File: tb/test_dmarq_front.sv
`timescale 1ns/1ps
// Self-checking bench for dmarq_front with two channels.
module test_dmarq_front;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] req_in, ch_enable, ch_prio, ch_dest_sync;
    logic       cyc_req, cyc_dest, cyc_ack;
    logic [0:0] cyc_ch;
    logic [3:0] cyc_left;

    int n_chk  = 0;
    int n_fail = 0;
    int rr     = 1;    // last offered channel, tracked by the bench
    bit done   = 0;

    always #2.5 clk = ~clk;

    dmarq_front i_dmarq_front (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .ch_enable(ch_enable),
        .ch_prio(ch_prio), .ch_dest_sync(ch_dest_sync), .cyc_req(cyc_req),
        .cyc_ch(cyc_ch), .cyc_dest(cyc_dest), .cyc_ack(cyc_ack),
        .cyc_left(cyc_left)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // One step: just after a falling edge (sample and drive point).
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Sequencer model: acknowledge now, then count len..1, then idle at 0.
    task automatic run_cycle(input int len);
        cyc_ack = 1'b1;
        step();
        cyc_ack  = 1'b0;
        cyc_left = 4'(len);
        chk("R4 offer dropped after ack", int'(cyc_req), 0);
        for (int k = 2; k <= len; k++) begin
            step();
            cyc_left = 4'(len - k + 1);
        end
        step();
        cyc_left = 4'd0;
    endtask

    // Raise one channel's line and check the exact offer cycle.
    task automatic latency(input int ch);
        req_in[ch] = 1'b1;
        repeat (3) step();
        chk("R2 no offer before third rising edge", int'(cyc_req), 0);
        step();
        chk("R2 offer on third rising edge", int'(cyc_req), 1);
        chk("R2 offered channel", int'(cyc_ch), ch);
        rr = ch;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_in = '0; ch_enable = 2'b11; ch_prio = '0;
        ch_dest_sync = '0; cyc_ack = 1'b0; cyc_left = '0;
        repeat (3) step();
        chk("R1 cyc_req in reset", int'(cyc_req), 0);
        chk("R1 cyc_ch in reset", int'(cyc_ch), 0);
        chk("R1 cyc_dest in reset", int'(cyc_dest), 0);
        rst_n = 1'b1;
        step();

        // R2: latency for each channel, line released after acknowledge (R8 low).
        for (int ch = 0; ch < 2; ch++) begin
            latency(ch);
            req_in[ch] = 1'b0;
            run_cycle(6);
            repeat (6) step();
            chk("R8 no re-offer when line low", int'(cyc_req), 0);
        end

        // R8: held line re-arms back-to-back over several cycle lengths.
        latency(0);
        for (int len = 4; len <= 8; len++) begin
            run_cycle(len);
            chk("R8 no offer before cycle end", int'(cyc_req), 0);
            step();
            chk("R8 re-offer right after cycle end", int'(cyc_req), 1);
            chk("R8 re-offered channel", int'(cyc_ch), 0);
            chk("R10 other channel not offered", int'(cyc_ch), 0);
        end
        req_in[0] = 1'b0;
        run_cycle(5);
        repeat (6) step();
        chk("R8 idle after final cycle", int'(cyc_req), 0);

        // R3: one-clock pulse still produces an offer.
        req_in[1] = 1'b1;
        step();
        req_in[1] = 1'b0;
        repeat (2) step();
        chk("R3 no offer yet", int'(cyc_req), 0);
        step();
        chk("R3 pulse offered", int'(cyc_req), 1);
        chk("R3 pulse channel", int'(cyc_ch), 1);
        rr = 1;
        run_cycle(5);
        repeat (6) step();
        chk("R3 idle after pulse cycle", int'(cyc_req), 0);

        // R9: disabled channel is masked, then needs full latency.
        ch_enable[0] = 1'b0;
        req_in[0] = 1'b1;
        repeat (8) step();
        chk("R9 masked request not offered", int'(cyc_req), 0);
        ch_enable[0] = 1'b1;
        repeat (3) step();
        chk("R9 full latency after enable", int'(cyc_req), 0);
        step();
        chk("R9 offer after enable", int'(cyc_req), 1);
        chk("R9 offered channel", int'(cyc_ch), 0);
        rr = 0;
        req_in[0] = 1'b0;
        run_cycle(5);
        repeat (6) step();

        // R9: disable right after capture discards the pending request.
        req_in[0] = 1'b1;
        step();
        req_in[0] = 1'b0;
        ch_enable[0] = 1'b0;
        repeat (3) step();
        ch_enable[0] = 1'b1;
        repeat (6) step();
        chk("R9 captured request dropped by disable", int'(cyc_req), 0);

        // R5/R6/R7: sweep priorities and modes with both channels competing.
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 4; m++) begin
                int win, los;
                ch_prio = 2'(p);
                ch_dest_sync = 2'(m);
                req_in = 2'b11;
                if (p == 1)      win = 0;
                else if (p == 2) win = 1;
                else             win = (rr == 0) ? 1 : 0;
                los = 1 - win;
                repeat (4) step();
                chk("R5/R6 first offer valid", int'(cyc_req), 1);
                if (p == 1 || p == 2) chk("R5 priority winner", int'(cyc_ch), win);
                else                  chk("R6 round-robin winner", int'(cyc_ch), win);
                chk("R7 winner mode", int'(cyc_dest), (m >> win) & 1);
                req_in = 2'b00;
                run_cycle(5);
                chk("R4 loser offered and held", int'(cyc_req), 1);
                chk("R6 loser channel", int'(cyc_ch), los);
                chk("R7 loser mode", int'(cyc_dest), (m >> los) & 1);
                rr = los;
                run_cycle(5);
                repeat (6) step();
                chk("R8 idle after both cycles", int'(cyc_req), 0);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule